// File: doc/BRIEF.md
# Secure Boot Image Copy Sequencer

This controller runs once after power-up. It keeps the processor cores in reset until it has looked at the boot-mode and boot-configuration inputs. It then lets them run in every mode. In the user-loader mode (mode 2) the cores first spin on a handoff register that reads zero. Meanwhile the sequencer fetches a loader image from non-volatile memory, starting at a page chosen by the configuration input.

The first two words of the image are a header. One is the RAM destination and the other is the body length, counted in 32-bit words. The sequencer copies the body word by word into on-chip RAM and folds each word into a running checksum. It then compares the result with the check word stored just after the body. On a match it writes the RAM entry address to the handoff register, and that nonzero value tells the cores to start. On a mismatch, or on a header that cannot fit, the effective boot mode drops to 0 and a sticky failure flag is raised. The handoff register then stays zero.

Reads from non-volatile memory are a request valid/ready handshake. The response arrives later, flagged by a response strobe, and the bench gives it one cycle after acceptance. A request stays asserted with a stable address until the memory accepts it. A RAM write likewise holds valid, address and data until ready is seen. Only one transfer is outstanding at a time, so either side may stall for any number of cycles.

Top module: `boot_copy_seq`

## Requirements
- R1: While `rst_n` is low: `core_rst_hold`=1, `handoff`=0, `boot_fail`=0, `eff_mode`=0, `done`=0, and no NVM request or RAM write is raised.
- R2: `core_rst_hold` falls on the first clock edge after reset ends, in every mode, and stays low. No NVM request is made while it is high.
- R3: When `boot_mode` is 0, 1 or 3, no NVM read and no RAM write happens. `eff_mode` takes the value of `boot_mode`, `handoff` stays 0 and `done` pulses.
- R4: In mode 2 (`boot_mode`=2'b10), NVM word addresses are read in increasing order from `boot_cfg`*2^PAGE_SH onward. The word at offset 0 is the RAM destination, given as a word address. The word at offset 1 is the body length in 32-bit words. The body follows, then one check word.
- R5: Body word i is written to RAM word address destination+i. Exactly length writes happen, in increasing address order.
- R6: The checksum starts at 0 and, for each body word d, becomes rotate-left-by-1(checksum) XOR d. If it equals the check word, `handoff` becomes RAM_BASE + 4*destination and `eff_mode` becomes 2.
- R7: On a checksum mismatch, `eff_mode` becomes 0, `boot_fail` becomes 1 and `handoff` stays 0.
- R8: A length of 0, or destination+length greater than 2^RAM_AW, fails as in R7 right after the header. Only the 2 header words are read and no RAM write happens.
- R9: A pending NVM request keeps valid and address stable until `nvm_req_ready`. A pending RAM write keeps valid, address and data stable until `ram_wr_ready`. The result does not depend on stall patterns.
- R10: `done` is high for exactly one cycle per boot. After it, `handoff`, `eff_mode` and `boot_fail` are frozen and `boot_mode` is ignored until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_mode | input | 2 | Requested boot mode 0..3 |
| boot_cfg | input | CFG_W | NVM page index of the loader image |
| core_rst_hold | output | 1 | Holds the cores in reset while high |
| nvm_req_valid | output | 1 | NVM read request valid |
| nvm_req_ready | input | 1 | NVM accepts the request |
| nvm_req_addr | output | NVM_AW | NVM word address |
| nvm_rsp_valid | input | 1 | Read data valid |
| nvm_rsp_data | input | 32 | Read data |
| ram_wr_valid | output | 1 | RAM write valid |
| ram_wr_ready | input | 1 | RAM accepts the write |
| ram_wr_addr | output | RAM_AW | RAM word address |
| ram_wr_data | output | 32 | RAM write data |
| handoff | output | 32 | Start address polled by the cores; 0 means wait |
| eff_mode | output | 2 | Effective boot mode, valid from `done` on |
| boot_fail | output | 1 | Sticky boot failure flag |
| done | output | 1 | One-cycle pulse at the end of the sequence |

## Verification
The non-loader modes 0, 1 and 3 are tried to separate the bypass path from the copy path. Several mode-2 images use different pages, destinations and lengths, including a length of 1 and a body that ends exactly at the top of RAM. These show that the address arithmetic, the word count and the checksum are right. A corrupted check word separates a checksum failure from a header failure, which is caught by the zero-length and overflowing-destination images through their read and write counts. Runs with pseudo-random ready stalls on both sides show that back-pressure changes timing only, and a reset in the middle of a copy shows the block returns cleanly to its idle state.

// File: rtl/boot_copy_pkg.sv
package boot_copy_pkg;

  typedef enum logic [2:0] {
    ST_START,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR,
    ST_FIN,
    ST_IDLE
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_DEST,
    PH_LEN,
    PH_BODY,
    PH_CHECK
  } word_phase_e;

  localparam logic [1:0] MODE_USER_LOADER = 2'b10;

  function automatic logic [31:0] rotl1(input logic [31:0] v);
    return {v[30:0], v[31]};
  endfunction

endpackage

// File: rtl/boot_step_ctr.sv
module boot_step_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= load_val;
    else if (inc)  q <= q + W'(1);
  end
endmodule

// File: rtl/boot_digest.sv
module boot_digest
  import boot_copy_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [31:0] din,
  output logic [31:0] sum
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sum <= '0;
    else if (clr) sum <= '0;
    else if (en)  sum <= rotl1(sum) ^ din;
  end
endmodule

// File: rtl/boot_hdr_check.sv
module boot_hdr_check #(
  parameter int          RAM_AW   = 10,
  parameter logic [31:0] RAM_BASE = 32'h0800_0000
) (
  input  logic [31:0] dst,
  input  logic [31:0] len,
  output logic        ok,
  output logic [31:0] vec_addr
);
  localparam logic [32:0] RAM_WORDS = 33'(1) << RAM_AW;

  logic [32:0] end_word;

  assign end_word = {1'b0, dst} + {1'b0, len};
  assign ok       = (len != 32'd0) && (end_word <= RAM_WORDS);
  assign vec_addr = RAM_BASE + {dst[29:0], 2'b00};
endmodule

// File: rtl/boot_copy_seq.sv
module boot_copy_seq
  import boot_copy_pkg::*;
#(
  parameter int          NVM_AW   = 16,
  parameter int          CFG_W    = 8,
  parameter int          PAGE_SH  = 6,
  parameter int          RAM_AW   = 10,
  parameter logic [31:0] RAM_BASE = 32'h0800_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        boot_mode,
  input  logic [CFG_W-1:0]  boot_cfg,
  output logic              core_rst_hold,
  output logic              nvm_req_valid,
  input  logic              nvm_req_ready,
  output logic [NVM_AW-1:0] nvm_req_addr,
  input  logic              nvm_rsp_valid,
  input  logic [31:0]       nvm_rsp_data,
  output logic              ram_wr_valid,
  input  logic              ram_wr_ready,
  output logic [RAM_AW-1:0] ram_wr_addr,
  output logic [31:0]       ram_wr_data,
  output logic [31:0]       handoff,
  output logic [1:0]        eff_mode,
  output logic              boot_fail,
  output logic              done
);
  localparam int CNT_W = RAM_AW + 1;

  seq_state_e        state;
  word_phase_e       phase;
  logic [31:0]       dst_q;
  logic [CNT_W-1:0]  len_q;
  logic [31:0]       data_q;
  logic [CNT_W-1:0]  body_cnt;
  logic [31:0]       digest_sum;
  logic              hdr_ok;
  logic [31:0]       vec_addr;
  logic [NVM_AW-1:0] page_base;
  logic              starting;
  logic              rd_fire;
  logic              wr_fire;

  assign page_base     = NVM_AW'({boot_cfg, {PAGE_SH{1'b0}}});
  assign starting      = (state == ST_START);
  assign nvm_req_valid = (state == ST_RD_REQ);
  assign ram_wr_valid  = (state == ST_WR);
  assign rd_fire       = nvm_req_valid && nvm_req_ready;
  assign wr_fire       = ram_wr_valid && ram_wr_ready;
  assign ram_wr_addr   = dst_q[RAM_AW-1:0] + body_cnt[RAM_AW-1:0];
  assign ram_wr_data   = data_q;
  assign done          = (state == ST_FIN);

  boot_step_ctr #(.W(NVM_AW)) u_rd_ctr (
    .clk(clk), .rst_n(rst_n), .load(starting), .load_val(page_base),
    .inc(rd_fire), .q(nvm_req_addr)
  );

  boot_step_ctr #(.W(CNT_W)) u_wr_ctr (
    .clk(clk), .rst_n(rst_n), .load(starting), .load_val('0),
    .inc(wr_fire), .q(body_cnt)
  );

  boot_digest u_digest (
    .clk(clk), .rst_n(rst_n), .clr(starting), .en(wr_fire),
    .din(data_q), .sum(digest_sum)
  );

  boot_hdr_check #(.RAM_AW(RAM_AW), .RAM_BASE(RAM_BASE)) u_hdr (
    .dst(dst_q), .len(nvm_rsp_data), .ok(hdr_ok), .vec_addr(vec_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_START;
      phase         <= PH_DEST;
      core_rst_hold <= 1'b1;
      dst_q         <= '0;
      len_q         <= '0;
      data_q        <= '0;
      handoff       <= '0;
      eff_mode      <= 2'd0;
      boot_fail     <= 1'b0;
    end else begin
      case (state)
        ST_START: begin
          core_rst_hold <= 1'b0;
          phase         <= PH_DEST;
          if (boot_mode == MODE_USER_LOADER) begin
            state <= ST_RD_REQ;
          end else begin
            eff_mode <= boot_mode;
            state    <= ST_FIN;
          end
        end
        ST_RD_REQ: begin
          if (nvm_req_ready) state <= ST_RD_WAIT;
        end
        ST_RD_WAIT: begin
          if (nvm_rsp_valid) begin
            case (phase)
              PH_DEST: begin
                dst_q <= nvm_rsp_data;
                phase <= PH_LEN;
                state <= ST_RD_REQ;
              end
              PH_LEN: begin
                if (hdr_ok) begin
                  len_q <= CNT_W'(nvm_rsp_data);
                  phase <= PH_BODY;
                  state <= ST_RD_REQ;
                end else begin
                  boot_fail <= 1'b1;
                  eff_mode  <= 2'd0;
                  state     <= ST_FIN;
                end
              end
              PH_BODY: begin
                data_q <= nvm_rsp_data;
                state  <= ST_WR;
              end
              default: begin
                if (nvm_rsp_data == digest_sum) begin
                  handoff  <= vec_addr;
                  eff_mode <= MODE_USER_LOADER;
                end else begin
                  boot_fail <= 1'b1;
                  eff_mode  <= 2'd0;
                end
                state <= ST_FIN;
              end
            endcase
          end
        end
        ST_WR: begin
          if (ram_wr_ready) begin
            if (body_cnt + CNT_W'(1) == len_q) phase <= PH_CHECK;
            state <= ST_RD_REQ;
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/boot_copy_seq_chk.sv
module boot_copy_seq_chk #(
  parameter int NVM_AW = 16,
  parameter int RAM_AW = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_rst_hold,
  input logic              nvm_req_valid,
  input logic              nvm_req_ready,
  input logic [NVM_AW-1:0] nvm_req_addr,
  input logic              ram_wr_valid,
  input logic              ram_wr_ready,
  input logic [RAM_AW-1:0] ram_wr_addr,
  input logic [31:0]       ram_wr_data,
  input logic [31:0]       handoff,
  input logic              boot_fail,
  input logic              done
);
  AST_REQ_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    nvm_req_valid |-> !core_rst_hold); // R2

  AST_RELEASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !core_rst_hold |=> !core_rst_hold); // R2

  AST_ONE_TRANSFER: assert property (@(posedge clk) disable iff (!rst_n)
    !(nvm_req_valid && ram_wr_valid)); // R5

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (nvm_req_valid && !nvm_req_ready) |=> (nvm_req_valid && $stable(nvm_req_addr))); // R9

  AST_WR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_wr_valid && !ram_wr_ready) |=>
      (ram_wr_valid && $stable(ram_wr_addr) && $stable(ram_wr_data))); // R9

  AST_HANDOFF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (handoff != 32'd0) |=> $stable(handoff)); // R6

  AST_FAIL_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    boot_fail |-> (handoff == 32'd0)); // R7

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    boot_fail |=> boot_fail); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!nvm_req_valid && !ram_wr_valid)); // R10
endmodule

bind boot_copy_seq boot_copy_seq_chk #(.NVM_AW(NVM_AW), .RAM_AW(RAM_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_rst_hold(core_rst_hold),
  .nvm_req_valid(nvm_req_valid), .nvm_req_ready(nvm_req_ready), .nvm_req_addr(nvm_req_addr),
  .ram_wr_valid(ram_wr_valid), .ram_wr_ready(ram_wr_ready), .ram_wr_addr(ram_wr_addr),
  .ram_wr_data(ram_wr_data), .handoff(handoff), .boot_fail(boot_fail), .done(done)
);

// File: tb/boot_copy_seq_tb_top.sv
module boot_copy_seq_tb_top;
  localparam int NVM_AW = 16;
  localparam int CFG_W  = 8;
  localparam int PAGE_SH = 6;
  localparam int RAM_AW = 10;
  localparam logic [31:0] RAM_BASE = 32'h0800_0000;

  typedef struct packed {
    logic [1:0]  mode;
    logic [3:0]  cfg;
    logic [31:0] dst;
    logic [31:0] len;
    logic        bad_dig;
    logic        stall;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'd0, 32'd0,    32'd0, 1'b0, 1'b0},
    '{2'd1, 4'd1, 32'd0,    32'd0, 1'b0, 1'b0},
    '{2'd3, 4'd2, 32'd0,    32'd0, 1'b0, 1'b1},
    '{2'd2, 4'd1, 32'h10,   32'd5, 1'b0, 1'b0},
    '{2'd2, 4'd2, 32'd0,    32'd1, 1'b0, 1'b1},
    '{2'd2, 4'd3, 32'h100,  32'd8, 1'b1, 1'b0},
    '{2'd2, 4'd4, 32'h40,   32'd0, 1'b0, 1'b0},
    '{2'd2, 4'd5, 32'd1020, 32'd5, 1'b0, 1'b1},
    '{2'd2, 4'd6, 32'd1019, 32'd5, 1'b0, 1'b1},
    '{2'd2, 4'd7, 32'h20,   32'd3, 1'b0, 1'b1}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        boot_mode = 2'd0;
  logic [CFG_W-1:0]  boot_cfg = '0;
  logic              core_rst_hold;
  logic              nvm_req_valid;
  logic              nvm_req_ready = 1'b1;
  logic [NVM_AW-1:0] nvm_req_addr;
  logic              nvm_rsp_valid;
  logic [31:0]       nvm_rsp_data;
  logic              ram_wr_valid;
  logic              ram_wr_ready = 1'b1;
  logic [RAM_AW-1:0] ram_wr_addr;
  logic [31:0]       ram_wr_data;
  logic [31:0]       handoff;
  logic [1:0]        eff_mode;
  logic              boot_fail;
  logic              done;

  always #10 clk = ~clk;

  boot_copy_seq #(.NVM_AW(NVM_AW), .CFG_W(CFG_W), .PAGE_SH(PAGE_SH),
                  .RAM_AW(RAM_AW), .RAM_BASE(RAM_BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode), .boot_cfg(boot_cfg),
    .core_rst_hold(core_rst_hold),
    .nvm_req_valid(nvm_req_valid), .nvm_req_ready(nvm_req_ready), .nvm_req_addr(nvm_req_addr),
    .nvm_rsp_valid(nvm_rsp_valid), .nvm_rsp_data(nvm_rsp_data),
    .ram_wr_valid(ram_wr_valid), .ram_wr_ready(ram_wr_ready), .ram_wr_addr(ram_wr_addr),
    .ram_wr_data(ram_wr_data), .handoff(handoff), .eff_mode(eff_mode),
    .boot_fail(boot_fail), .done(done)
  );

  int checks = 0;
  int fails  = 0;
  logic [31:0] nvm_mem [0:1023];
  logic [31:0] ram_mem [0:1023];
  int          rd_cnt, wr_cnt;
  logic        early_rd, order_err;
  logic [NVM_AW-1:0] first_addr;
  logic [31:0] exp_dst = '0;
  logic        stall = 1'b0;
  logic [7:0]  lfsr = 8'hA5;

  always @(posedge clk) begin
    if (!rst_n) begin
      nvm_rsp_valid <= 1'b0;
      nvm_rsp_data  <= '0;
      rd_cnt <= 0; wr_cnt <= 0; early_rd <= 1'b0; order_err <= 1'b0; first_addr <= '0;
    end else begin
      nvm_rsp_valid <= nvm_req_valid && nvm_req_ready;
      nvm_rsp_data  <= nvm_mem[nvm_req_addr[9:0]];
      if (nvm_req_valid && nvm_req_ready) begin
        rd_cnt <= rd_cnt + 1;
        if (rd_cnt == 0) first_addr <= nvm_req_addr;
        if (core_rst_hold) early_rd <= 1'b1;
      end
      if (ram_wr_valid && ram_wr_ready) begin
        ram_mem[ram_wr_addr] <= ram_wr_data;
        wr_cnt <= wr_cnt + 1;
        if (32'(ram_wr_addr) != exp_dst + 32'(wr_cnt)) order_err <= 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    nvm_req_ready <= stall ? lfsr[0] : 1'b1;
    ram_wr_ready  <= stall ? lfsr[3] : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] body_word(input int v, input int i);
    return 32'h9E37_0000 + 32'(v) * 32'h100 + 32'(i) * 32'h0101_0007;
  endfunction

  function automatic logic [31:0] ref_digest(input int v, input int n);
    logic [31:0] a = '0;
    for (int i = 0; i < n; i++) a = {a[30:0], a[31]} ^ body_word(v, i);
    return a;
  endfunction

  task automatic load_image(input int v);
    int base = int'(VECS[v].cfg) * 64;
    int n = int'(VECS[v].len);
    logic [31:0] d = ref_digest(v, n);
    nvm_mem[base]     = VECS[v].dst;
    nvm_mem[base + 1] = VECS[v].len;
    for (int i = 0; i < n; i++) nvm_mem[base + 2 + i] = body_word(v, i);
    nvm_mem[base + 2 + n] = VECS[v].bad_dig ? (d ^ 32'h1) : d;
  endtask

  task automatic check_reset_state(input string tag);
    chk(core_rst_hold == 1'b1, {tag, " R1 core held"}, 32'(core_rst_hold), 32'd1);
    chk(handoff == 32'd0, {tag, " R1 handoff"}, handoff, 32'd0);
    chk(boot_fail == 1'b0 && eff_mode == 2'd0, {tag, " R1 fail/mode"}, {29'd0, boot_fail, eff_mode}, 32'd0);
    chk(!done && !nvm_req_valid && !ram_wr_valid, {tag, " R1 quiet"},
        {29'd0, done, nvm_req_valid, ram_wr_valid}, 32'd0);
  endtask

  task automatic run_vec(input int v);
    vec_t t = VECS[v];
    bit   is_ldr = (t.mode == 2'd2);
    bit   hdr_ok = (t.len != 0) && ({1'b0, t.dst} + {1'b0, t.len} <= 33'd1024);
    logic [31:0] e_hand = '0;
    logic [1:0]  e_mode = t.mode;
    logic        e_fail = 1'b0;
    int          e_rd = 0, e_wr = 0;
    int          bad = 0;
    logic [31:0] h0;
    int          rd0;
    if (is_ldr) begin
      if (!hdr_ok) begin e_fail = 1; e_mode = 0; e_rd = 2; end
      else begin
        e_rd = int'(t.len) + 3; e_wr = int'(t.len);
        if (t.bad_dig) begin e_fail = 1; e_mode = 0; end
        else e_hand = RAM_BASE + (t.dst << 2);
      end
    end
    @(negedge clk);
    rst_n = 1'b0;
    boot_mode = t.mode; boot_cfg = CFG_W'(t.cfg); stall = t.stall; exp_dst = t.dst;
    load_image(v);
    repeat (3) @(negedge clk);
    check_reset_state($sformatf("vec%0d", v));
    rst_n = 1'b1;
    @(negedge clk);
    chk(core_rst_hold == 1'b0, "R2 released after first edge", 32'(core_rst_hold), 32'd0);
    for (int c = 0; c < 5000 && !done; c++) @(negedge clk);
    chk(done == 1'b1, "R10 done seen", 32'(done), 32'd1);
    chk(eff_mode == e_mode, is_ldr ? "R7 eff_mode" : "R3 eff_mode", 32'(eff_mode), 32'(e_mode));
    chk(handoff == e_hand, is_ldr ? "R6 handoff" : "R3 handoff", handoff, e_hand);
    chk(boot_fail == e_fail, (is_ldr && !hdr_ok) ? "R8 boot_fail" : "R7 boot_fail",
        32'(boot_fail), 32'(e_fail));
    chk(rd_cnt == e_rd, (is_ldr && !hdr_ok) ? "R8 read count" : "R4 read count", 32'(rd_cnt), 32'(e_rd));
    chk(wr_cnt == e_wr, (is_ldr && !hdr_ok) ? "R8 write count" : "R5 write count", 32'(wr_cnt), 32'(e_wr));
    chk(!early_rd, "R2 read while cores held", 32'(early_rd), 32'd0);
    chk(!order_err, "R5 write address order", 32'(order_err), 32'd0);
    if (is_ldr) begin
      chk(first_addr == NVM_AW'(int'(t.cfg) * 64), "R4 first read address",
          32'(first_addr), 32'(int'(t.cfg) * 64));
    end
    for (int i = 0; i < e_wr; i++)
      if (ram_mem[(int'(t.dst) + i) % 1024] !== body_word(v, i)) bad++;
    chk(bad == 0, t.stall ? "R9 stalled copy contents" : "R5 copy contents", 32'(bad), 32'd0);
    h0 = handoff; rd0 = rd_cnt;
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", 32'(done), 32'd0);
    boot_mode = ~boot_mode;
    repeat (6) @(negedge clk);
    chk(handoff == h0 && eff_mode == e_mode && boot_fail == e_fail && rd_cnt == rd0 && !done,
        "R10 frozen after done", handoff, h0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 1024; i++) begin nvm_mem[i] = '0; ram_mem[i] = '0; end
    repeat (2) @(negedge clk);
    check_reset_state("power-up");
    for (int v = 0; v < NV; v++) run_vec(v);
    // Directed: reset in the middle of a stalled copy returns to the reset state (R1).
    @(negedge clk);
    rst_n = 1'b0;
    boot_mode = VECS[9].mode; boot_cfg = CFG_W'(VECS[9].cfg); stall = 1'b1; exp_dst = VECS[9].dst;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (9) @(negedge clk);
    chk(!done && handoff == 32'd0, "R6 no start mid-copy", handoff, 32'd0);
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_state("mid-copy reset");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule